// File: doc/BRIEF.md
# Legacy I/O Chip-Select Decoder

This block turns ISA I/O cycles into active-low chip selects for fixed legacy peripherals. It watches the 16-bit I/O address, the read and write command strobes (IOR#, IOW#) and the address-enable line (AEN). From these it drives selects for the following targets:

- the keyboard controller;
- the embedded-controller mailbox;
- the real-time clock;
- a write-only POST-code port;
- a low-range "high decode" window;
- the index and data ports of the configuration interface.

Three strap pins are sampled while reset is asserted. After reset the same pins carry their normal functions, so the decoder uses only the latched copies.

The keyboard and mailbox selects share one strap, and the RTC select has its own. A third strap moves the configuration port pair from its default location to an alternate one. The high-range select is gated by a configuration bit that arrives on an input pin. All selects are combinational on the address and command strobes, so a peripheral sees its select within the same bus cycle.

Top module: `legacy_io_decode`

## Requirements
- R1: kbdSelN is low exactly when the address is 0060h or 0064h, a command is active, AEN is low and the latched keyboard strap was low.
- R2: ecSelN is low exactly when the address is 0062h or 0066h, under the same command, AEN and keyboard-strap conditions as R1.
- R3: rtcSelN is low exactly when the address is 0070h or 0071h, a command is active, AEN is low and the latched RTC strap was low.
- R4: postSelN is low only for address 0080h with iowN low and AEN low. It never asserts on a read, and it needs no strap.
- R5: With the latched config strap high, cfgIndexSelN decodes 004Eh and cfgDataSelN decodes 004Fh. With that strap low they decode 002Eh and 002Fh instead. Both need an active command and AEN low.
- R6: highSelN is low when address bits 15:11 are all zero, highRangeEn is 1, a command is active and AEN is low. Address 0800h or above never asserts it.
- R7: While aen is 1, every select output is high.
- R8: With both iorN and iowN high, every select output is high.
- R9: Each strap latch holds the pin value seen at the last rising clock edge with rstN low. Pin changes after reset have no effect on any select.
- R10: While rstN is low, every select output is high.

All select outputs and all strap pins are active-low. A command is active when iorN or iowN is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the strap latches |
| rstN | input | 1 | Active-low synchronous reset; straps are sampled while low |
| ioAddr | input | 16 | ISA I/O address |
| iorN | input | 1 | I/O read strobe, active-low |
| iowN | input | 1 | I/O write strobe, active-low |
| aen | input | 1 | Address enable; high during DMA cycles |
| highRangeEn | input | 1 | Configuration bit enabling the high-range select |
| strapKbdN | input | 1 | Strap: low enables the keyboard and mailbox selects |
| strapRtcN | input | 1 | Strap: low enables the RTC select |
| strapCfgAltN | input | 1 | Strap: low moves the configuration ports to 2Eh/2Fh |
| kbdSelN | output | 1 | Keyboard controller select |
| ecSelN | output | 1 | Embedded-controller mailbox select |
| rtcSelN | output | 1 | RTC select |
| postSelN | output | 1 | POST-code port select (writes only) |
| highSelN | output | 1 | High-range I/O select |
| cfgIndexSelN | output | 1 | Configuration index port hit |
| cfgDataSelN | output | 1 | Configuration data port hit |

## Verification
The assertions check several properties on every cycle:

- AEN high forces every select inactive.
- A POST select never coincides with a read-only cycle.
- An RTC select only appears for the two RTC addresses.
- The fixed-port selects are mutually exclusive.
- The latched straps stay constant outside reset.
- All selects stay inactive during reset.

Only the bench's scenarios can show that the right address produces the right select under each strap setting. The same holds for the move of the configuration pair between its two locations, and for the exact edges of the high-range window at 07FFh and 0800h. They also show that strap pins toggled after reset leave the decode unchanged.

// File: rtl/legacy_io_decode_pkg.sv
package legacy_io_decode_pkg;

  // Latched strap enables, already converted to active-high.
  typedef struct packed {
    logic kbdEn;
    logic rtcEn;
    logic cfgAlt;
  } strapSet_t;

  // Strobes from control to datapath / output gating.
  typedef struct packed {
    logic      anyCmd;   // read or write active, AEN low, out of reset
    logic      wrCmd;    // write active, AEN low, out of reset
    logic      hiEn;     // high-range window enabled
    strapSet_t straps;
  } ctrlStrobe_t;

  // Raw address hits from the datapath.
  typedef struct packed {
    logic kbdHit;
    logic ecHit;
    logic rtcHit;
    logic postHit;
    logic highHit;
    logic cfgIdxHit;
    logic cfgDatHit;
  } addrHit_t;

  localparam int NUM_SEL = 7;

endpackage

// File: rtl/legacy_io_decode_ctrl.sv
module legacy_io_decode_ctrl
  import legacy_io_decode_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        iorN,
  input  logic        iowN,
  input  logic        aen,
  input  logic        highRangeEn,
  input  logic        strapKbdN,
  input  logic        strapRtcN,
  input  logic        strapCfgAltN,
  output ctrlStrobe_t strobe
);

  strapSet_t strapQ;
  logic      strapValid;

  // Straps follow the pins on every edge while reset is held, then freeze.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      strapQ.kbdEn  <= ~strapKbdN;
      strapQ.rtcEn  <= ~strapRtcN;
      strapQ.cfgAlt <= ~strapCfgAltN;
      strapValid    <= 1'b1;
    end
  end

  logic cmdLive;
  logic wrLive;

  always_comb begin
    cmdLive = rstN && !aen && (!iorN || !iowN);
    wrLive  = rstN && !aen && !iowN;

    strobe.anyCmd = cmdLive;
    strobe.wrCmd  = wrLive;
    strobe.hiEn   = highRangeEn;
    strobe.straps = strapValid ? strapQ : '0;
  end

  // R9: latched straps do not move once reset has been released
  a_r9_strap_hold: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> $stable(strapQ));

endmodule

// File: rtl/legacy_io_decode_match.sv
module legacy_io_decode_match
  import legacy_io_decode_pkg::*;
#(
  parameter int          ADDR_W       = 16,
  parameter int          HIGH_LSB     = 11,
  parameter logic [15:0] KBD_PORT_A   = 16'h0060,
  parameter logic [15:0] KBD_PORT_B   = 16'h0064,
  parameter logic [15:0] EC_PORT_A    = 16'h0062,
  parameter logic [15:0] EC_PORT_B    = 16'h0066,
  parameter logic [15:0] RTC_PORT     = 16'h0070,
  parameter logic [15:0] POST_PORT    = 16'h0080,
  parameter logic [15:0] CFG_PORT_PRI = 16'h004E,
  parameter logic [15:0] CFG_PORT_ALT = 16'h002E
) (
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic              cfgAlt,
  output addrHit_t          hits
);

  localparam int NUM_FIXED = 6;
  localparam int HIGH_W    = ADDR_W - HIGH_LSB;

  // Fixed single-address ports, compared in parallel.
  localparam logic [15:0] FIXED_PORTS [NUM_FIXED] = '{
    KBD_PORT_A, KBD_PORT_B, EC_PORT_A, EC_PORT_B, RTC_PORT, RTC_PORT + 16'd1
  };

  logic [NUM_FIXED-1:0] fixedHit;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_FIXED; gi++) begin : g_fixed
      assign fixedHit[gi] = (ioAddr == FIXED_PORTS[gi][ADDR_W-1:0]);
    end
  endgenerate

  logic [ADDR_W-1:0] cfgBase;
  logic              cfgPairHit;

  always_comb begin
    cfgBase    = cfgAlt ? CFG_PORT_ALT[ADDR_W-1:0] : CFG_PORT_PRI[ADDR_W-1:0];
    cfgPairHit = (ioAddr[ADDR_W-1:1] == cfgBase[ADDR_W-1:1]);

    hits.kbdHit    = fixedHit[0] | fixedHit[1];
    hits.ecHit     = fixedHit[2] | fixedHit[3];
    hits.rtcHit    = fixedHit[4] | fixedHit[5];
    hits.postHit   = (ioAddr == POST_PORT[ADDR_W-1:0]);
    hits.highHit   = (ioAddr[ADDR_W-1:HIGH_LSB] == HIGH_W'(0));
    hits.cfgIdxHit = cfgPairHit && !ioAddr[0];
    hits.cfgDatHit = cfgPairHit &&  ioAddr[0];
  end

endmodule

// File: rtl/legacy_io_decode.sv
module legacy_io_decode
  import legacy_io_decode_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int HIGH_LSB = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic              iorN,
  input  logic              iowN,
  input  logic              aen,
  input  logic              highRangeEn,
  input  logic              strapKbdN,
  input  logic              strapRtcN,
  input  logic              strapCfgAltN,
  output logic              kbdSelN,
  output logic              ecSelN,
  output logic              rtcSelN,
  output logic              postSelN,
  output logic              highSelN,
  output logic              cfgIndexSelN,
  output logic              cfgDataSelN
);

  ctrlStrobe_t strobe;
  addrHit_t    hits;

  legacy_io_decode_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .iorN         (iorN),
    .iowN         (iowN),
    .aen          (aen),
    .highRangeEn  (highRangeEn),
    .strapKbdN    (strapKbdN),
    .strapRtcN    (strapRtcN),
    .strapCfgAltN (strapCfgAltN),
    .strobe       (strobe)
  );

  legacy_io_decode_match #(
    .ADDR_W   (ADDR_W),
    .HIGH_LSB (HIGH_LSB)
  ) u_match (
    .ioAddr (ioAddr),
    .cfgAlt (strobe.straps.cfgAlt),
    .hits   (hits)
  );

  always_comb begin
    kbdSelN      = ~(strobe.anyCmd && strobe.straps.kbdEn && hits.kbdHit);
    ecSelN       = ~(strobe.anyCmd && strobe.straps.kbdEn && hits.ecHit);
    rtcSelN      = ~(strobe.anyCmd && strobe.straps.rtcEn && hits.rtcHit);
    postSelN     = ~(strobe.wrCmd  && hits.postHit);
    highSelN     = ~(strobe.anyCmd && strobe.hiEn && hits.highHit);
    cfgIndexSelN = ~(strobe.anyCmd && hits.cfgIdxHit);
    cfgDataSelN  = ~(strobe.anyCmd && hits.cfgDatHit);
  end

  logic [NUM_SEL-1:0] selActive;
  assign selActive = ~{kbdSelN, ecSelN, rtcSelN, postSelN, highSelN,
                       cfgIndexSelN, cfgDataSelN};

  // R7: DMA cycles never produce a select
  a_r7_aen_blocks: assert property (@(posedge clk) disable iff (!rstN)
    aen |-> (selActive == '0));

  // R4: POST port only on writes
  a_r4_post_write_only: assert property (@(posedge clk) disable iff (!rstN)
    !postSelN |-> !iowN);

  // R3: RTC select confined to its two addresses
  a_r3_rtc_range: assert property (@(posedge clk) disable iff (!rstN)
    !rtcSelN |-> (ioAddr[ADDR_W-1:1] == (ADDR_W-1)'(16'h0038)));

  // R1 R2 R3 R4 R5: fixed-port selects are mutually exclusive
  a_r1_fixed_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({selActive[6:3], selActive[1:0]}));

  // R8: no command, no select
  a_r8_need_cmd: assert property (@(posedge clk) disable iff (!rstN)
    (iorN && iowN) |-> (selActive == '0));

  // R10: reset keeps all selects inactive
  always_ff @(posedge clk) begin
    if (!rstN) begin
      a_r10_reset_idle: assert (selActive == '0);
    end
  end

endmodule

// File: tb/legacy_io_decode_tb.sv
module legacy_io_decode_tb;

  logic        clk = 1'b0;
  logic        rstN;
  logic [15:0] ioAddr;
  logic        iorN, iowN, aen, highRangeEn;
  logic        strapKbdN, strapRtcN, strapCfgAltN;
  logic        kbdSelN, ecSelN, rtcSelN, postSelN, highSelN;
  logic        cfgIndexSelN, cfgDataSelN;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  legacy_io_decode u_dut (
    .clk(clk), .rstN(rstN), .ioAddr(ioAddr), .iorN(iorN), .iowN(iowN),
    .aen(aen), .highRangeEn(highRangeEn), .strapKbdN(strapKbdN),
    .strapRtcN(strapRtcN), .strapCfgAltN(strapCfgAltN),
    .kbdSelN(kbdSelN), .ecSelN(ecSelN), .rtcSelN(rtcSelN),
    .postSelN(postSelN), .highSelN(highSelN),
    .cfgIndexSelN(cfgIndexSelN), .cfgDataSelN(cfgDataSelN)
  );

  // Active-high view: {kbd, ec, rtc, post, high, cfgIdx, cfgDat}
  function automatic logic [6:0] actNow();
    return ~{kbdSelN, ecSelN, rtcSelN, postSelN, highSelN,
             cfgIndexSelN, cfgDataSelN};
  endfunction

  localparam logic [6:0] K = 7'b1000000, E = 7'b0100000, T = 7'b0010000,
                         P = 7'b0001000, H = 7'b0000100, I = 7'b0000010,
                         D = 7'b0000001, N = 7'b0000000;

  typedef struct packed {
    logic [15:0] addr;
    logic        rdN;
    logic        wrN;
    logic        dma;
    logic        hiEn;
    logic [6:0]  exp;
    logic [3:0]  req;
  } vec_t;

  // All straps latched low: keyboard and RTC enabled, config at 2Eh/2Fh.
  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    '{16'h0060, 1'b0, 1'b1, 1'b0, 1'b0, K,     4'd1},  // R1
    '{16'h0064, 1'b1, 1'b0, 1'b0, 1'b0, K,     4'd1},  // R1
    '{16'h0062, 1'b0, 1'b1, 1'b0, 1'b0, E,     4'd2},  // R2
    '{16'h0066, 1'b1, 1'b0, 1'b0, 1'b0, E,     4'd2},  // R2
    '{16'h0070, 1'b0, 1'b1, 1'b0, 1'b0, T,     4'd3},  // R3
    '{16'h0071, 1'b1, 1'b0, 1'b0, 1'b0, T,     4'd3},  // R3
    '{16'h0080, 1'b1, 1'b0, 1'b0, 1'b0, P,     4'd4},  // R4 write
    '{16'h0080, 1'b0, 1'b1, 1'b0, 1'b0, N,     4'd4},  // R4 read ignored
    '{16'h002E, 1'b0, 1'b1, 1'b0, 1'b0, I,     4'd5},  // R5
    '{16'h002F, 1'b1, 1'b0, 1'b0, 1'b0, D,     4'd5},  // R5
    '{16'h004E, 1'b0, 1'b1, 1'b0, 1'b0, N,     4'd5},  // R5 moved away
    '{16'h0060, 1'b0, 1'b1, 1'b0, 1'b1, K | H, 4'd6},  // R6
    '{16'h07FF, 1'b0, 1'b1, 1'b0, 1'b1, H,     4'd6},  // R6 top edge
    '{16'h0800, 1'b0, 1'b1, 1'b0, 1'b1, N,     4'd6},  // R6 outside
    '{16'h0060, 1'b0, 1'b1, 1'b1, 1'b1, N,     4'd7},  // R7
    '{16'h0080, 1'b1, 1'b0, 1'b1, 1'b0, N,     4'd7},  // R7
    '{16'h0060, 1'b1, 1'b1, 1'b0, 1'b1, N,     4'd8},  // R8
    '{16'h0061, 1'b0, 1'b1, 1'b0, 1'b0, N,     4'd1},  // R1 neighbour
    '{16'h0072, 1'b0, 1'b1, 1'b0, 1'b0, N,     4'd3}   // R3 neighbour
  };

  task automatic check(input logic [6:0] exp, input int req, input string what);
    checks++;
    if (actNow() !== exp) begin
      errors++;
      $display("FAIL R%0d %s: got %b expected %b", req, what, actNow(), exp);
    end
  endtask

  task automatic drive(input logic [15:0] a, input logic r, input logic w,
                       input logic d, input logic h);
    @(negedge clk);
    ioAddr = a; iorN = r; iowN = w; aen = d; highRangeEn = h;
    #1;
  endtask

  task automatic doReset(input logic kbdN, input logic rtcN, input logic cfgN);
    @(negedge clk);
    rstN = 1'b0;
    strapKbdN = kbdN; strapRtcN = rtcN; strapCfgAltN = cfgN;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin : watchdog
    #400000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rstN = 1'b0; ioAddr = 16'h0060; iorN = 1'b0; iowN = 1'b1; aen = 1'b0;
    highRangeEn = 1'b1; strapKbdN = 1'b0; strapRtcN = 1'b0; strapCfgAltN = 1'b0;

    // R10: selects stay idle while reset is held, even on a matching read
    repeat (2) @(negedge clk);
    #1 check(N, 10, "reset idle on 0060h read");
    ioAddr = 16'h0080; iorN = 1'b1; iowN = 1'b0;
    #1 check(N, 10, "reset idle on 0080h write");

    doReset(1'b0, 1'b0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].addr, VECS[i].rdN, VECS[i].wrN, VECS[i].dma, VECS[i].hiEn);
      check(VECS[i].exp, int'(VECS[i].req), $sformatf("vector %0d", i));
    end

    // R9: pins toggled after reset must not change the decode
    @(negedge clk);
    strapKbdN = 1'b1; strapRtcN = 1'b1; strapCfgAltN = 1'b1;
    repeat (3) @(negedge clk);
    drive(16'h0064, 1'b0, 1'b1, 1'b0, 1'b0);
    check(K, 9, "kbd after strap pin change");
    drive(16'h0071, 1'b0, 1'b1, 1'b0, 1'b0);
    check(T, 9, "rtc after strap pin change");
    drive(16'h002E, 1'b0, 1'b1, 1'b0, 1'b0);
    check(I, 9, "cfg stays at 2Eh after pin change");

    // Straps latched high: fixed selects disabled, config at default location
    doReset(1'b1, 1'b1, 1'b1);
    drive(16'h0060, 1'b0, 1'b1, 1'b0, 1'b0);
    check(N, 1, "kbd disabled by strap");
    drive(16'h0066, 1'b1, 1'b0, 1'b0, 1'b0);
    check(N, 2, "mailbox disabled by strap");
    drive(16'h0070, 1'b0, 1'b1, 1'b0, 1'b0);
    check(N, 3, "rtc disabled by strap");
    drive(16'h0080, 1'b1, 1'b0, 1'b0, 1'b0);
    check(P, 4, "post needs no strap");
    drive(16'h004E, 1'b0, 1'b1, 1'b0, 1'b0);
    check(I, 5, "cfg index default 4Eh");
    drive(16'h004F, 1'b1, 1'b0, 1'b0, 1'b0);
    check(D, 5, "cfg data default 4Fh");
    drive(16'h002E, 1'b0, 1'b1, 1'b0, 1'b0);
    check(N, 5, "2Eh idle in default mode");
    drive(16'h0000, 1'b0, 1'b1, 1'b0, 1'b1);
    check(H, 6, "high window at 0000h");
    drive(16'h0000, 1'b0, 1'b1, 1'b0, 1'b0);
    check(N, 6, "high window disabled");

    // R9: the value at the last reset edge wins over earlier samples
    @(negedge clk);
    rstN = 1'b0; strapKbdN = 1'b1;
    @(negedge clk);
    strapKbdN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    strapKbdN = 1'b1;
    drive(16'h0060, 1'b0, 1'b1, 1'b0, 1'b0);
    check(K, 9, "last sample during reset latched");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule